// File: doc/BRIEF.md
# Tightly-Coupled Memory Address Router

This block sits between a processor's load, store or fetch unit and its memory paths. Every request carries an address. The block compares that address against a set of fixed windows, up to four of them. Each window is a power-of-two span aligned to its own size, and each one has a private memory port. A request that lands in a window goes to that window's port. Any other request goes to the cached path with its address, byte enables and write data unchanged. A window access never touches the cache, so the cache behaves as if it were absent for that span.

Two rules apply only to window addresses. A cache maintenance request whose address falls inside a window is accepted and then discarded: neither the cache nor the window port sees it. When address translation is on, a non-maintenance request made in user mode to a window is refused. In that case no port is driven, and a fault strobe pulses for one cycle.

The request side uses a valid/ready handshake. A request transfers on a cycle where `req_valid` and `req_ready` are both high. For cache-bound requests `req_ready` follows `cache_ready`, so the cache can hold off the requester. Window-bound, dropped and faulting requests are always accepted at once. Window memories have a fixed one-cycle read latency, so responses carry a valid strobe and no ready. One instance serves one stream, instructions or data; a core uses two instances.

Top module: `tcm_router`

## Requirements
- R1: Window i covers the addresses a with (a >> WIN_LOG2[i]) == (WIN_BASE[i] >> WIN_LOG2[i]). While a window request is presented, only `tcm_cs[i]` is high, and port i carries the offset a - WIN_BASE[i], all in the same cycle. Bit i of `tcm_cs` belongs to window i.
- R2: When windows overlap, the lowest-numbered matching window receives the request.
- R3: A request that matches no window raises `cache_valid` with its address, write flag, byte enables, write data and maintenance flag unchanged. No window port is selected while `cache_valid` is high.
- R4: `req_ready` equals `cache_ready` for a cache-bound request. It is 1 for requests that match a window.
- R5: A window read produces `rsp_valid` high for exactly one cycle, one cycle after the request, with `rsp_data` taken from that window's port. A window write produces no response.
- R6: A window write drives `tcm_we`, `tcm_be` and `tcm_wdata` only on the selected window's port. Only the byte lanes enabled in `req_be` (bit k for bits 8k+7..8k) change in memory.
- R7: A maintenance request (`req_cmo` = 1) whose address lies in a window reaches neither the cache nor any window port. It raises no fault and produces no response. Outside the windows it goes to the cache with `cache_cmo` = 1.
- R8: With `xlate_en` = 1 and `req_user` = 1, a non-maintenance window request drives no port and no cache request. `fault_o` is high for exactly the one cycle after the request, and no response is produced.
- R9: With `xlate_en` = 0, or with `req_user` = 0, a window access is served normally.
- R10: During reset, `rsp_valid` and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Address translation enabled |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| req_be | input | DW/8 | Byte enables |
| req_wdata | input | DW | Store data |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_cmo | input | 1 | Cache maintenance request |
| cache_valid | output | 1 | Request to cached path |
| cache_ready | input | 1 | Cached path can accept |
| cache_addr | output | AW | Address to cache |
| cache_write | output | 1 | Store flag to cache |
| cache_be | output | DW/8 | Byte enables to cache |
| cache_wdata | output | DW | Store data to cache |
| cache_cmo | output | 1 | Maintenance flag to cache |
| tcm_cs | output | NWIN | Per-window chip select |
| tcm_we | output | NWIN | Per-window write enable |
| tcm_addr | output | NWIN*AW | Per-window offset, window i at bits i*AW |
| tcm_be | output | NWIN*DW/8 | Per-window byte enables |
| tcm_wdata | output | NWIN*DW | Per-window store data |
| tcm_rdata | input | NWIN*DW | Per-window read data, one cycle after select |
| rsp_valid | output | 1 | Window read data valid |
| rsp_data | output | DW | Window read data |
| fault_o | output | 1 | Privilege fault strobe |

## Verification
The routing outputs (`tcm_cs`, the window port fields, `cache_valid` with its fields, and `req_ready`) are combinational and are due in the same cycle as the request. The bench drives each request on a falling edge and checks these outputs 1 ns later, before the rising edge. `rsp_valid`, `rsp_data` and `fault_o` are due one rising edge after the request. They are checked at the next falling edge, when the request has already been withdrawn, and `fault_o` is checked once more a cycle later to confirm that it is a single pulse. The sweep covers every word address in a 16 KiB space in supervisor mode. Fault, maintenance, write and back-pressure cases use addresses in each window and between windows.

// File: rtl/tcm_router_pkg.sv
package tcm_router_pkg;
  localparam int MAX_WIN = 4;

  typedef enum logic [1:0] {
    ROUTE_CACHE = 2'd0,
    ROUTE_TCM   = 2'd1,
    ROUTE_FAULT = 2'd2,
    ROUTE_DROP  = 2'd3
  } route_e;
endpackage

// File: rtl/tcm_win_decode.sv
module tcm_win_decode #(
  parameter int AW = 16,
  parameter int NWIN = 4,
  parameter logic [NWIN*AW-1:0] WIN_BASE = '0,
  parameter logic [NWIN*8-1:0] WIN_LOG2 = '0
) (
  input  logic [AW-1:0]   addr,
  output logic [NWIN-1:0] sel,
  output logic            hit_any,
  output logic [AW-1:0]   offset
);
  logic [NWIN-1:0]   raw;
  logic [AW-1:0]     off_w [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int          L      = int'(WIN_LOG2[i*8 +: 8]);
    localparam logic [AW-1:0] BASE = WIN_BASE[i*AW +: AW];
    localparam logic [AW-1:0] LOMASK = AW'((64'd1 << L) - 64'd1);
    assign raw[i]   = ((addr ^ BASE) & ~LOMASK) == '0;
    assign off_w[i] = addr & LOMASK;
  end

  always_comb begin
    logic taken;
    taken  = 1'b0;
    sel    = '0;
    offset = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (raw[i] && !taken) begin
        sel[i] = 1'b1;
        offset = off_w[i];
        taken  = 1'b1;
      end
    end
    hit_any = taken;
  end
endmodule

// File: rtl/tcm_port_steer.sv
module tcm_port_steer #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NWIN = 4,
  localparam int BEW = DW / 8
) (
  input  logic              fire,
  input  logic [NWIN-1:0]   sel,
  input  logic [AW-1:0]     offset,
  input  logic              write,
  input  logic [BEW-1:0]    be,
  input  logic [DW-1:0]     wdata,
  output logic [NWIN-1:0]   tcm_cs,
  output logic [NWIN-1:0]   tcm_we,
  output logic [NWIN*AW-1:0]  tcm_addr,
  output logic [NWIN*BEW-1:0] tcm_be,
  output logic [NWIN*DW-1:0]  tcm_wdata
);
  for (genvar i = 0; i < NWIN; i++) begin : g_port
    assign tcm_cs[i]               = fire & sel[i];
    assign tcm_we[i]               = fire & sel[i] & write;
    assign tcm_addr[i*AW +: AW]    = sel[i] ? offset : '0;
    assign tcm_be[i*BEW +: BEW]    = sel[i] ? be : '0;
    assign tcm_wdata[i*DW +: DW]   = sel[i] ? wdata : '0;
  end
endmodule

// File: rtl/tcm_rsp_return.sv
module tcm_rsp_return #(
  parameter int DW = 32,
  parameter int NWIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWIN-1:0]   rd_sel,
  input  logic              fault_fire,
  input  logic [NWIN*DW-1:0] tcm_rdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              fault_o
);
  logic [NWIN-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      rsp_valid <= 1'b0;
      fault_o   <= 1'b0;
    end else begin
      sel_q     <= rd_sel;
      rsp_valid <= |rd_sel;
      fault_o   <= fault_fire;
    end
  end

  always_comb begin
    rsp_data = '0;
    for (int i = 0; i < NWIN; i++)
      if (sel_q[i]) rsp_data = rsp_data | tcm_rdata[i*DW +: DW];
  end

  // R8
  rsp_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && fault_o));

  // R5
  rsp_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot(sel_q));
endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcm_router_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NWIN = 4,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {16'h1000, 16'h3000, 16'h2000, 16'h1000},
  parameter logic [NWIN*8-1:0]  WIN_LOG2 = {8'd12, 8'd10, 8'd6, 8'd8},
  localparam int BEW = DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlate_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_write,
  input  logic [BEW-1:0]       req_be,
  input  logic [DW-1:0]        req_wdata,
  input  logic                 req_user,
  input  logic                 req_cmo,
  output logic                 cache_valid,
  input  logic                 cache_ready,
  output logic [AW-1:0]        cache_addr,
  output logic                 cache_write,
  output logic [BEW-1:0]       cache_be,
  output logic [DW-1:0]        cache_wdata,
  output logic                 cache_cmo,
  output logic [NWIN-1:0]      tcm_cs,
  output logic [NWIN-1:0]      tcm_we,
  output logic [NWIN*AW-1:0]   tcm_addr,
  output logic [NWIN*BEW-1:0]  tcm_be,
  output logic [NWIN*DW-1:0]   tcm_wdata,
  input  logic [NWIN*DW-1:0]   tcm_rdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_data,
  output logic                 fault_o
);
  logic [NWIN-1:0] sel;
  logic            hit_any;
  logic [AW-1:0]   offset;
  route_e          route;

  tcm_win_decode #(.AW(AW), .NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_dec (
    .addr(req_addr), .sel(sel), .hit_any(hit_any), .offset(offset));

  always_comb begin
    if (!hit_any)                   route = ROUTE_CACHE;
    else if (req_cmo)               route = ROUTE_DROP;
    else if (xlate_en && req_user)  route = ROUTE_FAULT;
    else                            route = ROUTE_TCM;
  end

  assign req_ready   = (route == ROUTE_CACHE) ? cache_ready : 1'b1;
  assign cache_valid = req_valid && (route == ROUTE_CACHE);
  assign cache_addr  = req_addr;
  assign cache_write = req_write;
  assign cache_be    = req_be;
  assign cache_wdata = req_wdata;
  assign cache_cmo   = req_cmo;

  tcm_port_steer #(.AW(AW), .DW(DW), .NWIN(NWIN)) u_steer (
    .fire(req_valid && (route == ROUTE_TCM)), .sel(sel), .offset(offset),
    .write(req_write), .be(req_be), .wdata(req_wdata),
    .tcm_cs(tcm_cs), .tcm_we(tcm_we), .tcm_addr(tcm_addr),
    .tcm_be(tcm_be), .tcm_wdata(tcm_wdata));

  tcm_rsp_return #(.DW(DW), .NWIN(NWIN)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_sel(tcm_cs & ~tcm_we),
    .fault_fire(req_valid && (route == ROUTE_FAULT)),
    .tcm_rdata(tcm_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fault_o(fault_o));

  // R1
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tcm_cs));

  // R3
  cache_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid |-> (tcm_cs == '0));

  // R4
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (cache_valid && !cache_ready));

  // R5
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past((tcm_cs & ~tcm_we) != '0));

  // R7
  cmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmo && (tcm_cs == '0)) |-> ##1 !rsp_valid && !fault_o);

  // R8
  fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(req_valid && req_user && xlate_en && !req_cmo && !cache_valid));
endmodule

// File: tb/tcm_router_test.sv
module tcm_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        xlate_en, req_valid, req_ready, req_write, req_user, req_cmo;
  logic [15:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        cache_valid, cache_ready, cache_write, cache_cmo;
  logic [15:0] cache_addr;
  logic [3:0]  cache_be;
  logic [31:0] cache_wdata;
  logic [3:0]  tcm_cs, tcm_we;
  logic [63:0] tcm_addr;
  logic [15:0] tcm_be;
  logic [127:0] tcm_wdata, tcm_rdata;
  logic        rsp_valid, fault_o;
  logic [31:0] rsp_data;

  tcm_router uut (.*);

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [4][1024];
  logic [31:0] rdq [4];
  always_comb for (int w = 0; w < 4; w++) tcm_rdata[w*32 +: 32] = rdq[w];
  always @(posedge clk) begin
    for (int w = 0; w < 4; w++) begin
      if (tcm_cs[w] && tcm_we[w]) begin
        for (int k = 0; k < 4; k++)
          if (tcm_be[w*4+k]) mem[w][tcm_addr[w*16+2 +: 10]][k*8 +: 8] <= tcm_wdata[w*32+k*8 +: 8];
      end else if (tcm_cs[w]) rdq[w] <= mem[w][tcm_addr[w*16+2 +: 10]];
    end
  end

  int wr_w = -1;
  int wr_idx = -1;
  logic [31:0] wr_val;

  function automatic int exp_win(input int a);
    if (a >= 'h1000 && a < 'h1100) return 0;
    if (a >= 'h2000 && a < 'h2040) return 1;
    if (a >= 'h3000 && a < 'h3400) return 2;
    if (a >= 'h1000 && a < 'h2000) return 3;
    return -1;
  endfunction

  function automatic int exp_base(input int w);
    case (w)
      1: return 'h2000;
      2: return 'h3000;
      default: return 'h1000;
    endcase
  endfunction

  function automatic logic [31:0] exp_data(input int w, input int idx);
    if (w == wr_w && idx == wr_idx) return wr_val;
    return {8'(w + 1), 8'h00, 16'(idx)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // route: 0 cache, 1 window, 2 fault, 3 drop
  task automatic access(input int a, input bit wr, input logic [3:0] be, input logic [31:0] wd,
                        input bit user, input bit cmo, input bit xl, input string tag);
    int w, rt, base;
    bit ok;
    w = exp_win(a);
    if (w < 0) rt = 0;
    else if (cmo) rt = 3;
    else if (xl && user) rt = 2;
    else rt = 1;
    base = (w < 0) ? 0 : exp_base(w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'(a); req_write = wr; req_be = be; req_wdata = wd;
    req_user = user; req_cmo = cmo; xlate_en = xl;
    #1;
    if (rt == 1) begin
      ok = tcm_cs == 4'(1 << w) && tcm_addr[w*16 +: 16] == 16'(a - base) && !cache_valid
           && req_ready && tcm_we == (wr ? 4'(1 << w) : 4'h0);
      if (wr) ok = ok && tcm_be[w*4 +: 4] == be && tcm_wdata[w*32 +: 32] == wd;
      chk(ok, tag, {tcm_cs, tcm_we, tcm_addr[w*16 +: 16], 7'd0, cache_valid, 7'd0, req_ready},
          {4'(1 << w), wr ? 4'(1 << w) : 4'h0, 16'(a - base), 8'd0, 8'd1});
    end else if (rt == 0) begin
      ok = tcm_cs == 0 && cache_valid && cache_addr == 16'(a) && cache_write == wr
           && cache_be == be && cache_wdata == wd && cache_cmo == cmo && req_ready == cache_ready;
      chk(ok, tag, {tcm_cs, 3'd0, cache_valid, cache_addr, 3'd0, req_ready},
          {4'h0, 4'h1, 16'(a), 3'd0, cache_ready});
    end else begin
      ok = tcm_cs == 0 && !cache_valid && req_ready;
      chk(ok, tag, {tcm_cs, 3'd0, cache_valid, 3'd0, req_ready}, {4'h0, 4'h0, 4'h1});
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (rt == 1 && !wr) begin
      chk(rsp_valid && !fault_o && rsp_data == exp_data(w, (a - base) / 4), {tag, " R5 rsp"},
          {31'd0, rsp_valid, rsp_data}, {31'd0, 1'b1, exp_data(w, (a - base) / 4)});
    end else begin
      chk(!rsp_valid && fault_o == (rt == 2), {tag, " R8 rsp/fault"},
          {62'd0, rsp_valid, fault_o}, {62'd0, 1'b0, rt == 2});
    end
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin
      rdq[w] = '0;
      for (int i = 0; i < 1024; i++) mem[w][i] = {8'(w + 1), 8'h00, 16'(i)};
    end
    xlate_en = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_be = 4'hF;
    req_wdata = '0; req_user = 1'b0; req_cmo = 1'b0; cache_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!rsp_valid && !fault_o, "R10 reset", {62'd0, rsp_valid, fault_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R9: supervisor read sweep over every word
    for (int a = 0; a < 'h4000; a += 4)
      access(a, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0, 1'b1,
             (a >= 'h1000 && a < 'h1100) ? "R2 overlap" : "R1/R3 sweep");

    // R8 user faults with translation on
    access('h1004, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b1, "R8 user w0");
    @(negedge clk); #1;
    chk(!fault_o, "R8 single pulse", {63'd0, fault_o}, 64'd0);
    access('h2010, 1'b1, 4'hF, 32'h1234, 1'b1, 1'b0, 1'b1, "R8 user write w1");
    access('h33FC, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b1, "R8 user w2");
    access('h1800, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b1, "R8 user w3");
    access('h0800, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b1, "R3 user outside");
    // R9 user with translation off
    access('h1004, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b0, "R9 user xlate off w0");
    access('h303C, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b0, "R9 user xlate off w2");
    // R7 maintenance
    access('h1040, 1'b0, 4'hF, 0, 1'b0, 1'b1, 1'b1, "R7 cmo w0");
    access('h1F00, 1'b0, 4'hF, 0, 1'b1, 1'b1, 1'b1, "R7 cmo w3 user");
    access('h2000, 1'b0, 4'hF, 0, 1'b0, 1'b1, 1'b0, "R7 cmo w1");
    access('h2040, 1'b0, 4'hF, 0, 1'b0, 1'b1, 1'b1, "R7 cmo outside");
    // R6 writes then read back
    access('h2008, 1'b1, 4'b0101, 32'hAABBCCDD, 1'b0, 1'b0, 1'b1, "R6 write w1");
    wr_w = 1; wr_idx = 2;
    wr_val = 32'h02000002;
    wr_val[7:0] = 8'hDD; wr_val[23:16] = 8'hBB;
    access('h2008, 1'b0, 4'hF, 0, 1'b0, 1'b0, 1'b1, "R6 readback w1");
    access('h1008, 1'b0, 4'hF, 0, 1'b0, 1'b0, 1'b1, "R6 w0 untouched");
    access('h3008, 1'b0, 4'hF, 0, 1'b0, 1'b0, 1'b1, "R6 w2 untouched");
    access('h0100, 1'b1, 4'b1010, 32'h55667788, 1'b0, 1'b0, 1'b1, "R3 write to cache");
    // R4 back-pressure
    cache_ready = 1'b0;
    access('h0200, 1'b0, 4'hF, 0, 1'b0, 1'b0, 1'b1, "R4 cache stall");
    access('h4000 - 4, 1'b1, 4'h3, 32'h9, 1'b0, 1'b0, 1'b1, "R4 cache stall write");
    access('h1100, 1'b0, 4'hF, 0, 1'b0, 1'b0, 1'b1, "R4 window while stalled");
    access('h1000, 1'b0, 4'hF, 0, 1'b1, 1'b0, 1'b1, "R4 fault while stalled");
    cache_ready = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule